// File: doc/BRIEF.md
# GPIO Port Register Block with Bit-Masked Write Aliases

This block is the register front end for one 8-pin general-purpose I/O port. A simple register bus (address, write strobe, write data, read strobe, read data) reaches four writable per-pin registers: pin function select, drive enable, drive value and interrupt enable. A fifth, read-only register shows the pin levels after a two-flop synchronizer. The stored registers feed the pad drivers and a downstream interrupt detector directly.

Every writable register has two addresses. The plain address replaces all eight bits. The masked address, 0x800 higher, treats the upper byte of the write data as a per-bit update enable, so one pin can be changed without a read-modify-write and without racing other writers. Software that turns a pin into an output sets the drive value first and the drive enable second, so the pad never drives a stale level.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the function-select, drive-enable, drive-value and interrupt-enable registers are all 0, so every pad output enable, pad value, function select and interrupt enable output is 0 and the read data is 0.
- R2: A write strobe at a plain offset (function select 0x000, drive enable 0x010, drive value 0x020, interrupt enable 0x050) stores write data bits 7:0 in that register, visible on its output the cycle after the write edge.
- R3: A write strobe at a masked offset (0x800, 0x810, 0x820, 0x850) updates bit n of the addressed register to write data bit n only where write data bit 8+n is 1; all other bits keep their value.
- R4: pad_oe_o bit n is the drive-enable register bit n (1 drives the pin, 0 leaves it an input); pad_out_o, func_sel_o and irq_en_o are the drive-value, function-select and interrupt-enable registers.
- R5: A change on pin_i appears on pin_sync_o, and in the input register, after exactly two rising clock edges.
- R6: A read strobe loads rd_data_o at the clock edge with the addressed register in bits 7:0 and 0 in bits 31:8; offset 0x030 returns the synchronized pin levels. rd_data_o holds between reads.
- R7: A read of any offset not listed in R2 or R6, including every masked offset (0x800-0x870) and the unmapped 0x040, 0x060, 0x070, returns 0.
- R8: A write strobe at an offset not listed in R2 or R3 (such as 0x030, 0x040, 0x840, 0x860) changes no register, and a write changes only the register it addresses.
- R9: When drive value is written before drive enable, a pin's enable bit never rises in the same cycle as its value bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data; bits 15:8 are the bit mask in masked writes |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| pin_i | input | 8 | Asynchronous pin levels |
| pin_sync_o | output | 8 | Synchronized pin levels to the interrupt detector |
| func_sel_o | output | 8 | Per-pin function select |
| pad_oe_o | output | 8 | Pad drive enable |
| pad_out_o | output | 8 | Pad drive value |
| irq_en_o | output | 8 | Per-pin interrupt enable |

## Verification
On every cycle the assertions check that a plain write lands whole, that a masked write leaves unselected bits untouched, that a register not addressed stays stable, that read data carries zeros above bit 7 and that unmapped reads return 0, plus that no enable bit rises alongside a value change. Only the bench scenarios show the reset values, the two-edge synchronizer latency on the input register, the drive-value-then-enable sequence seen at the pads, and that writes to read-only or unmapped offsets leave all four registers unchanged when read back.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int NUM_WREG   = 4;
  localparam int OFS_FSEL   = 'h000;
  localparam int OFS_DRV_EN = 'h010;
  localparam int OFS_DRV    = 'h020;
  localparam int OFS_PIN    = 'h030;
  localparam int OFS_IRQ_EN = 'h050;
  localparam int MASK_ALIAS = 'h800;

  // index order of the writable registers
  localparam int IDX_FSEL   = 0;
  localparam int IDX_DRV_EN = 1;
  localparam int IDX_DRV    = 2;
  localparam int IDX_IRQ_EN = 3;

  function automatic int wreg_ofs(input int idx);
    case (idx)
      IDX_FSEL:   return OFS_FSEL;
      IDX_DRV_EN: return OFS_DRV_EN;
      IDX_DRV:    return OFS_DRV;
      default:    return OFS_IRQ_EN;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mreg.sv
module gpio_mreg #(
  parameter int W  = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_plain_i,
  input  logic          wr_mask_i,
  input  logic [DW-1:0] wdata_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] val, sel;
  assign val = wdata_i[W-1:0];
  assign sel = wdata_i[2*W-1:W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= '0;
    else if (wr_plain_i) q_o <= val;
    else if (wr_mask_i)  q_o <= (q_o & ~sel) | (val & sel);
  end

  p_plain_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_plain_i |=> q_o == $past(val));
  p_mask_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_i |=> ((q_o ^ $past(q_o)) & ~$past(sel)) == '0);
  p_mask_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_i |=> (q_o & $past(sel)) == ($past(val) & $past(sel)));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_plain_i || wr_mask_i) |=> $stable(q_o));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   pin_sync_o,
  output logic [PINS-1:0]   func_sel_o,
  output logic [PINS-1:0]   pad_oe_o,
  output logic [PINS-1:0]   pad_out_o,
  output logic [PINS-1:0]   irq_en_o
);
  localparam int PAD_W = DATA_W - PINS;

  logic [PINS-1:0] reg_q [NUM_WREG];
  logic [NUM_WREG-1:0] hit_plain;

  for (genvar i = 0; i < NUM_WREG; i++) begin : g_wreg
    logic wr_plain, wr_mask;
    assign hit_plain[i] = addr_i == ADDR_W'(wreg_ofs(i));
    assign wr_plain = wr_en_i && hit_plain[i];
    assign wr_mask  = wr_en_i && (addr_i == ADDR_W'(wreg_ofs(i) | MASK_ALIAS));
    gpio_mreg #(.W(PINS), .DW(DATA_W)) u_reg (
      .clk_i, .rst_ni,
      .wr_plain_i (wr_plain),
      .wr_mask_i  (wr_mask),
      .wdata_i    (wr_data_i),
      .q_o        (reg_q[i])
    );
  end

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync_o)
  );

  assign func_sel_o = reg_q[IDX_FSEL];
  assign pad_oe_o   = reg_q[IDX_DRV_EN];
  assign pad_out_o  = reg_q[IDX_DRV];
  assign irq_en_o   = reg_q[IDX_IRQ_EN];

  logic            rd_hit;
  logic [PINS-1:0] rd_val;
  always_comb begin
    rd_hit = 1'b0;
    rd_val = '0;
    for (int i = 0; i < NUM_WREG; i++) begin
      if (hit_plain[i]) begin
        rd_hit = 1'b1;
        rd_val = reg_q[i];
      end
    end
    if (addr_i == ADDR_W'(OFS_PIN)) begin
      rd_hit = 1'b1;
      rd_val = pin_sync_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_hit ? {{PAD_W{1'b0}}, rd_val} : '0;
  end

  p_rd_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:PINS] == '0);
  p_rd_unmapped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_hit) |=> rd_data_o == '0);
  p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  p_oe_after_value_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~$past(pad_oe_o)) & (pad_out_o ^ $past(pad_out_o))) == '0);
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic [7:0]  pin = '0, pin_sync, fsel, oe, dout, irqen;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .pin_i(pin), .pin_sync_o(pin_sync), .func_sel_o(fsel),
    .pad_oe_o(oe), .pad_out_o(dout), .irq_en_o(irqen)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic t_reset;
    chk("R1 fsel", {24'h0, fsel}, 0);
    chk("R1 oe", {24'h0, oe}, 0);
    chk("R1 out", {24'h0, dout}, 0);
    chk("R1 irqen", {24'h0, irqen}, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_plain;
    logic [31:0] d;
    bus_wr(12'h000, 32'hFFFF_FF5A); chk("R2 fsel", {24'h0, fsel}, 32'h5A);
    bus_wr(12'h050, 32'h0000_00C3); chk("R2 R4 irqen", {24'h0, irqen}, 32'hC3);
    bus_rd(12'h000, d); chk("R6 read fsel", d, 32'h5A);
    bus_rd(12'h050, d); chk("R6 read irqen", d, 32'hC3);
  endtask

  task automatic t_masked;
    logic [31:0] d;
    bus_wr(12'h800, 32'h0000_0F0A); // fsel 5A -> low nibble to A
    chk("R3 masked fsel", {24'h0, fsel}, 32'h5A);
    bus_wr(12'h800, 32'h0000_8100); // clear bits 7,0
    chk("R3 masked clear", {24'h0, fsel}, 32'h5A);
    bus_wr(12'h800, 32'h0000_0300); // clear bits 1,0 -> 58
    chk("R3 masked clear2", {24'h0, fsel}, 32'h58);
    bus_wr(12'h850, 32'h0000_00FF); // zero mask: no change
    chk("R3 zero mask", {24'h0, irqen}, 32'hC3);
    bus_rd(12'h800, d); chk("R7 masked read", d, 0);
  endtask

  task automatic t_drive_order;
    bus_wr(12'h820, 32'h0000_0808);
    chk("R9 value first out", {24'h0, dout}, 32'h08);
    chk("R9 value first oe", {24'h0, oe}, 0);
    bus_wr(12'h810, 32'h0000_0808);
    chk("R4 oe on", {24'h0, oe}, 32'h08);
    chk("R4 out held", {24'h0, dout}, 32'h08);
    bus_wr(12'h810, 32'h0000_0800);
    chk("R4 oe off", {24'h0, oe}, 0);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk); pin = 8'hA5;
    @(negedge clk); chk("R5 one edge", {24'h0, pin_sync}, 0);
    @(negedge clk); chk("R5 two edges", {24'h0, pin_sync}, 32'hA5);
    bus_rd(12'h030, d); chk("R5 R6 input reg", d, 32'hA5);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    bus_wr(12'h030, 32'hFFFF_FFFF);
    bus_wr(12'h040, 32'hFFFF_FFFF);
    bus_wr(12'h840, 32'hFFFF_FFFF);
    bus_wr(12'h860, 32'hFFFF_FFFF);
    bus_wr(12'h004, 32'hFFFF_FFFF);
    bus_rd(12'h000, d); chk("R8 fsel kept", d, 32'h58);
    bus_rd(12'h010, d); chk("R8 oe kept", d, 0);
    bus_rd(12'h020, d); chk("R8 out kept", d, 32'h08);
    bus_rd(12'h050, d); chk("R8 irqen kept", d, 32'hC3);
    bus_rd(12'h060, d); chk("R7 unmapped 060", d, 0);
    bus_rd(12'h070, d); chk("R7 unmapped 070", d, 0);
    bus_rd(12'h830, d); chk("R7 masked 830", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_plain();
    t_masked();
    t_drive_order();
    t_sync();
    t_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule